// File: doc/BRIEF.md
# DTMF Digit Decoder with Guard-Time Steering

This block sits behind a tone detector that reports, every clock cycle, whether a dual-tone pair is present, which of the four low-group rows it belongs to and which of the four high-group columns it belongs to. It turns every row/column pair into a 4-bit digit code. It applies guard-time steering before it declares a digit. A pair must persist for a programmable number of cycles before the data-valid flag rises. After it goes away, the pair must stay absent for a second programmable number of cycles before the flag falls.

An early steering flag follows the presence of an acceptable pair with one cycle of delay and gives no qualification. The block captures the digit code when data-valid rises and holds it until the next digit is validated. The code is presented on a data bus that is gated by an output-enable input, together with a drive flag that models a tri-state output. An inhibit input rejects the fourth column, which carries keys A to D. A power-down input freezes detection and keeps the captured code.

Top module: `dtmf_steer_top`

## Requirements
- R1: Keypad rows 0..3 and columns 0..3 map to keys 1 2 3 A / 4 5 6 B / 7 8 9 C / * 0 # D. Digits 1-9 give codes 1-9, 0 gives 10, * gives 11, # gives 12, and A, B, C, D give 13, 14, 15, 0.
- R2: While `inhibit` is 1, a pair with column 3 raises neither `early_steer` nor `data_valid`. Columns 0-2 are still accepted. With `inhibit` at 0, column 3 decodes normally.
- R3: `early_steer` is 1 on the clock edge after an accepted pair is sampled. It is 0 on the edge after no accepted pair is sampled.
- R4: Let A be `acq_cycles`, with 0 treated as 1. `data_valid` rises at the (A+1)-th consecutive edge that samples the same accepted pair. A change of row or column before that point restarts the count.
- R5: A pair that vanishes before its acquisition count completes never raises `data_valid`.
- R6: Let R be `rel_cycles`, with 0 treated as 1. Once valid, `data_valid` falls at the (R+1)-th consecutive edge without the same accepted pair. A gap of R edges or fewer, followed by the same pair, keeps `data_valid` high.
- R7: The code is captured on the edge where `data_valid` rises. It is held after `data_valid` falls and until the next validated digit.
- R8: With `out_en` at 1, `digit_out` shows the captured code and `bus_drive` is 1. With `out_en` at 0, `digit_out` is 0 and `bus_drive` is 0. The change takes effect without waiting for a clock edge.
- R9: With `pwr_down` sampled at 1, `early_steer` and `data_valid` are 0 after that edge and the counters clear. The captured code is kept. After power-down ends, a full acquisition is needed again.
- R10: After synchronous reset, `early_steer` and `data_valid` are 0 and the captured code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_down | input | 1 | Stops detection; clears the steering state |
| inhibit | input | 1 | Rejects pairs in column 3 |
| tone_present | input | 1 | Upstream detector reports a tone pair |
| row_idx | input | 2 | Low-group row index |
| col_idx | input | 2 | High-group column index |
| acq_cycles | input | 16 | Acquisition guard length in cycles |
| rel_cycles | input | 16 | Release guard length in cycles |
| out_en | input | 1 | Data output enable |
| early_steer | output | 1 | Unqualified pair-present flag |
| data_valid | output | 1 | Guard-qualified digit flag |
| digit_out | output | 4 | Captured digit code, zero when disabled |
| bus_drive | output | 1 | High when the data bus would be driven |

## Verification
The hardest states to reach from the ports are the release window being bridged and the acquisition window being restarted. Reaching them needs a dropout or a pair swap of an exact length, placed at a known distance from the edge that entered the window. The bench drives all inputs at a fixed offset after each edge and counts edges from the first sampling edge. It first probes one cycle before the expected transition, where the flag must not have moved, and then on the cycle of the transition. The bench also runs power-down while a digit is valid and then keeps the tone present. This shows that the captured code survives and that the guard count starts again from zero.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;
  localparam int ROW_W  = 2;
  localparam int COL_W  = 2;
  localparam int CODE_W = 4;
  localparam int NROWS  = 1 << ROW_W;
  localparam int NCOLS  = 1 << COL_W;
  localparam int NKEYS  = NROWS * NCOLS;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACQ   = 2'd1,
    ST_VALID = 2'd2,
    ST_REL   = 2'd3
  } steer_state_t;

  // Digit code for one keypad position.
  function automatic logic [CODE_W-1:0] key_code(input logic [ROW_W-1:0] r,
                                                 input logic [COL_W-1:0] c);
    logic [CODE_W-1:0] v;
    if (c == COL_W'(NCOLS - 1)) begin
      v = 4'd13 + {2'b00, r};               // letter column, D wraps to 0
    end else if (r == ROW_W'(NROWS - 1)) begin
      case (c)
        2'd0:    v = 4'd11;                 // star
        2'd1:    v = 4'd10;                 // zero
        default: v = 4'd12;                 // hash
      endcase
    end else begin
      v = ({2'b00, r} * 4'd3) + {2'b00, c} + 4'd1;
    end
    return v;
  endfunction
endpackage

// File: rtl/dtmf_key_decode.sv
module dtmf_key_decode
  import dtmf_pkg::*;
(
  input  logic              tone_present,
  input  logic              inhibit,
  input  logic              pwr_down,
  input  logic [ROW_W-1:0]  row_idx,
  input  logic [COL_W-1:0]  col_idx,
  output logic              accept,
  output logic [CODE_W-1:0] code
);
  localparam int KEY_W = ROW_W + COL_W;

  logic [CODE_W-1:0] rom [NKEYS];
  logic              letter_col;

  for (genvar gi = 0; gi < NKEYS; gi++) begin : g_rom
    assign rom[gi] = key_code(ROW_W'(gi / NCOLS), COL_W'(gi % NCOLS));
  end

  assign letter_col = (col_idx == COL_W'(NCOLS - 1));
  assign accept     = tone_present && !(inhibit && letter_col) && !pwr_down;
  assign code       = rom[KEY_W'({row_idx, col_idx})];
endmodule

// File: rtl/dtmf_steer_fsm.sv
module dtmf_steer_fsm
  import dtmf_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   pwr_down,
  input  logic                   accept,
  input  logic [ROW_W+COL_W-1:0] pair,
  input  logic [CNT_W-1:0]       acq_cycles,
  input  logic [CNT_W-1:0]       rel_cycles,
  output logic                   early_steer,
  output logic                   data_valid,
  output logic                   capture
);
  localparam int PAIR_W = ROW_W + COL_W;

  steer_state_t       st_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [PAIR_W-1:0]  pair_q;
  logic [CNT_W-1:0]   acq_eff, rel_eff;
  logic               same;

  assign acq_eff = (acq_cycles == '0) ? CNT_W'(1) : acq_cycles;
  assign rel_eff = (rel_cycles == '0) ? CNT_W'(1) : rel_cycles;
  assign same    = accept && (pair == pair_q);
  assign capture = (st_q == ST_ACQ) && same && (cnt_q >= acq_eff)
                   && !rst && !pwr_down;

  always_ff @(posedge clk) begin
    if (rst || pwr_down) begin
      st_q        <= ST_IDLE;
      cnt_q       <= '0;
      pair_q      <= '0;
      early_steer <= 1'b0;
      data_valid  <= 1'b0;
    end else begin
      early_steer <= accept;
      case (st_q)
        ST_IDLE: begin
          if (accept) begin
            st_q   <= ST_ACQ;
            pair_q <= pair;
            cnt_q  <= CNT_W'(1);
          end
        end
        ST_ACQ: begin
          if (!accept) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
          end else if (pair != pair_q) begin
            pair_q <= pair;
            cnt_q  <= CNT_W'(1);
          end else if (cnt_q >= acq_eff) begin
            st_q       <= ST_VALID;
            cnt_q      <= '0;
            data_valid <= 1'b1;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_VALID: begin
          if (!same) begin
            st_q  <= ST_REL;
            cnt_q <= CNT_W'(1);
          end
        end
        default: begin // ST_REL
          if (same) begin
            st_q  <= ST_VALID;
            cnt_q <= '0;
          end else if (cnt_q >= rel_eff) begin
            st_q       <= ST_IDLE;
            cnt_q      <= '0;
            data_valid <= 1'b0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
      endcase
    end
  end

  p_rise_from_acq_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(data_valid) |-> ($past(st_q) == ST_ACQ));

  p_fall_after_window_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(data_valid) |-> (($past(st_q) == ST_REL) || $past(pwr_down)));

  p_rise_with_est_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(data_valid) |-> early_steer);

  p_pd_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    pwr_down |=> (!data_valid && !early_steer && (st_q == ST_IDLE)));
endmodule

// File: rtl/dtmf_out_hold.sv
module dtmf_out_hold
  import dtmf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [CODE_W-1:0] code_in,
  input  logic              out_en,
  output logic [CODE_W-1:0] code_q,
  output logic [CODE_W-1:0] digit_out,
  output logic              bus_drive
);
  always_ff @(posedge clk) begin
    if (rst)          code_q <= '0;
    else if (capture) code_q <= code_in;
  end

  assign bus_drive = out_en;
  assign digit_out = out_en ? code_q : '0;
endmodule

// File: rtl/dtmf_steer_top.sv
module dtmf_steer_top
  import dtmf_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_down,
  input  logic              inhibit,
  input  logic              tone_present,
  input  logic [1:0]        row_idx,
  input  logic [1:0]        col_idx,
  input  logic [CNT_W-1:0]  acq_cycles,
  input  logic [CNT_W-1:0]  rel_cycles,
  input  logic              out_en,
  output logic              early_steer,
  output logic              data_valid,
  output logic [3:0]        digit_out,
  output logic              bus_drive
);
  logic              accept;
  logic              capture;
  logic [CODE_W-1:0] code_now;
  logic [CODE_W-1:0] code_q;

  dtmf_key_decode u_dec (
    .tone_present (tone_present),
    .inhibit      (inhibit),
    .pwr_down     (pwr_down),
    .row_idx      (row_idx),
    .col_idx      (col_idx),
    .accept       (accept),
    .code         (code_now)
  );

  dtmf_steer_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .pwr_down    (pwr_down),
    .accept      (accept),
    .pair        ({row_idx, col_idx}),
    .acq_cycles  (acq_cycles),
    .rel_cycles  (rel_cycles),
    .early_steer (early_steer),
    .data_valid  (data_valid),
    .capture     (capture)
  );

  dtmf_out_hold u_out (
    .clk       (clk),
    .rst       (rst),
    .capture   (capture),
    .code_in   (code_now),
    .out_en    (out_en),
    .code_q    (code_q),
    .digit_out (digit_out),
    .bus_drive (bus_drive)
  );

  p_inhibit_blocks_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(data_valid) |-> $past(tone_present && !(inhibit && (col_idx == 2'd3))));

  p_code_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !$rose(data_valid) |-> $stable(code_q));
endmodule

// File: tb/tb_dtmf_steer_top.sv
module tb_dtmf_steer_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pwr_down = 1'b0;
  logic        inhibit = 1'b0;
  logic        tone_present = 1'b0;
  logic [1:0]  row_idx = '0;
  logic [1:0]  col_idx = '0;
  logic [15:0] acq_cycles = 16'd3;
  logic [15:0] rel_cycles = 16'd2;
  logic        out_en = 1'b1;
  logic        early_steer, data_valid, bus_drive;
  logic [3:0]  digit_out;

  int checks = 0;
  int errors = 0;

  dtmf_steer_top dut (
    .clk(clk), .rst(rst), .pwr_down(pwr_down), .inhibit(inhibit),
    .tone_present(tone_present), .row_idx(row_idx), .col_idx(col_idx),
    .acq_cycles(acq_cycles), .rel_cycles(rel_cycles), .out_en(out_en),
    .early_steer(early_steer), .data_valid(data_valid),
    .digit_out(digit_out), .bus_drive(bus_drive)
  );

  always #10 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_code(input int r, input int c);
    string keys;
    byte   k;
    keys = "123A456B789C*0#D";
    k = keys[r*4 + c];
    case (k)
      "0": return 10;
      "*": return 11;
      "#": return 12;
      "A": return 13;
      "B": return 14;
      "C": return 15;
      "D": return 0;
      default: return int'(k) - int'("0");
    endcase
  endfunction

  function automatic int eff(input logic [15:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  task automatic set_tone(input logic on, input int r, input int c);
    tone_present = on;
    row_idx = 2'(r);
    col_idx = 2'(c);
  endtask

  task automatic press(input int r, input int c);
    set_tone(1'b1, r, c);
    tick(eff(acq_cycles) + 1);
  endtask

  task automatic release_key();
    tone_present = 1'b0;
    tick(eff(rel_cycles) + 1);
  endtask

  task automatic t_reset();
    chk("R10 dv", data_valid, 0);
    chk("R10 est", early_steer, 0);
    chk("R10 code", digit_out, 0);
  endtask

  task automatic t_map_all();
    acq_cycles = 16'd2; rel_cycles = 16'd1;
    for (int r = 0; r < 4; r++) begin
      for (int c = 0; c < 4; c++) begin
        press(r, c);
        chk("R1 dv", data_valid, 1);
        chk("R1 code", digit_out, exp_code(r, c));
        release_key();
        chk("R1 release", data_valid, 0);
      end
    end
  endtask

  task automatic t_est();
    acq_cycles = 16'd4;
    chk("R3 idle", early_steer, 0);
    set_tone(1'b1, 1, 1);
    tick(1);
    chk("R3 rise", early_steer, 1);
    chk("R3 dv still low", data_valid, 0);
    tone_present = 1'b0;
    tick(1);
    chk("R3 fall", early_steer, 0);
    tick(3);
  endtask

  task automatic t_acq_timing();
    acq_cycles = 16'd6; rel_cycles = 16'd2;
    set_tone(1'b1, 0, 1);
    tick(6);
    chk("R4 before", data_valid, 0);
    tick(1);
    chk("R4 at", data_valid, 1);
    chk("R4 code", digit_out, 2);
    release_key();
    acq_cycles = 16'd0;
    set_tone(1'b1, 2, 2);
    tick(1);
    chk("R4 zero-as-one before", data_valid, 0);
    tick(1);
    chk("R4 zero-as-one at", data_valid, 1);
    release_key();
  endtask

  task automatic t_pair_restart();
    acq_cycles = 16'd5; rel_cycles = 16'd2;
    set_tone(1'b1, 0, 0);
    tick(3);
    set_tone(1'b1, 2, 1);
    tick(5);
    chk("R4 restart before", data_valid, 0);
    tick(1);
    chk("R4 restart at", data_valid, 1);
    chk("R4 restart code", digit_out, 8);
    release_key();
  endtask

  task automatic t_dropout();
    acq_cycles = 16'd5;
    set_tone(1'b1, 1, 2);
    tick(4);
    tone_present = 1'b0;
    tick(10);
    chk("R5 no dv", data_valid, 0);
    chk("R5 code kept", digit_out, 8);
    chk("R5 est low", early_steer, 0);
  endtask

  task automatic t_release();
    acq_cycles = 16'd2; rel_cycles = 16'd4;
    press(1, 0);
    chk("R6 valid", data_valid, 1);
    tone_present = 1'b0;
    tick(4);
    chk("R6 bridge held", data_valid, 1);
    tone_present = 1'b1;
    tick(3);
    chk("R6 bridge back", data_valid, 1);
    tone_present = 1'b0;
    tick(4);
    chk("R6 before fall", data_valid, 1);
    tick(1);
    chk("R6 fall", data_valid, 0);
    chk("R7 held after fall", digit_out, 4);
  endtask

  task automatic t_inhibit();
    acq_cycles = 16'd2; rel_cycles = 16'd1;
    inhibit = 1'b1;
    set_tone(1'b1, 1, 3);
    tick(8);
    chk("R2 no dv", data_valid, 0);
    chk("R2 no est", early_steer, 0);
    chk("R2 code kept", digit_out, 4);
    tone_present = 1'b0;
    tick(1);
    press(0, 0);
    chk("R2 col0 ok", data_valid, 1);
    chk("R2 col0 code", digit_out, 1);
    release_key();
    inhibit = 1'b0;
    press(1, 3);
    chk("R2 released dv", data_valid, 1);
    chk("R2 released code", digit_out, 14);
    release_key();
  endtask

  task automatic t_pd();
    acq_cycles = 16'd3; rel_cycles = 16'd2;
    press(2, 0);
    chk("R9 pre valid", data_valid, 1);
    pwr_down = 1'b1;
    tick(1);
    chk("R9 dv off", data_valid, 0);
    chk("R9 est off", early_steer, 0);
    chk("R9 code kept", digit_out, 7);
    tick(10);
    chk("R9 stays off", data_valid, 0);
    pwr_down = 1'b0;
    tick(3);
    chk("R9 reacquire before", data_valid, 0);
    tick(1);
    chk("R9 reacquire at", data_valid, 1);
    release_key();
  endtask

  task automatic t_oe();
    out_en = 1'b0;
    #1;
    chk("R8 off data", digit_out, 0);
    chk("R8 off drive", bus_drive, 0);
    out_en = 1'b1;
    #1;
    chk("R8 on data", digit_out, 7);
    chk("R8 on drive", bus_drive, 1);
    acq_cycles = 16'd2;
    out_en = 1'b0;
    press(3, 2);
    out_en = 1'b1;
    #1;
    chk("R7 captured while disabled", digit_out, 12);
    release_key();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    t_reset();
    t_map_all();
    t_est();
    t_acq_timing();
    t_pair_restart();
    t_dropout();
    t_release();
    t_inhibit();
    t_pd();
    t_oe();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule